// File: doc/BRIEF.md
# Byte-Serial Coprocessor Command Front End

This block sits between a small 8-bit host controller and a single-precision arithmetic unit. The host sends one command frame over an 8-bit parallel link. Every byte on that link uses a four-phase request/acknowledge exchange.

A frame starts with an opcode byte and carries two 32-bit operands. When the frame is complete, the block fires the arithmetic unit through a start/done pair. It then returns a 32-bit word to the host on a second byte path, using the same four-phase exchange in the other direction.

The returned word is normally the arithmetic result. A mode-toggle opcode switches the block into a latency-measurement mode. In that mode the returned word is the number of clock cycles the arithmetic unit needed, counted from start to done.

The host runs from its own clock. Its strobe and acknowledge lines therefore pass through two synchronising flip-flops before any decision is made on them.

Top module: `fpu_byte_link`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `c_ack_o`, `c_stb_o`, `fu_start_o` and `busy_o` to 0 and turns latency mode off.
- R2: Inbound handshake timing:
  - `c_ack_o` rises on the third rising edge after `h_stb_i` goes high. That is two synchroniser stages plus one state register.
  - `c_ack_o` stays high while the strobe is high.
  - `c_ack_o` falls on the third rising edge after `h_stb_i` goes low.
- R3: Outbound handshake:
  - `c_stb_o` stays high, with `c_data_o` unchanged, until `h_ack_i` is seen high.
  - `c_stb_o` falls on the third rising edge after `h_ack_i` rises.
  - The next byte is offered only after `h_ack_i` is seen low again.
- R4: Frame order on the inbound link is: opcode, then operand A most significant byte first, then operand B most significant byte first. Opcodes 0x00, 0x01, 0x02 and 0x03 select add, subtract, multiply and divide. These appear as codes 0 to 3 on `fu_op_o`, with the operands on `fu_a_o` and `fu_b_o`.
- R5: Start pulse:
  - `fu_start_o` is a single-cycle pulse, issued exactly once per arithmetic frame.
  - It is raised on the same edge at which `c_ack_o` falls for the eighth operand byte.
- R6: Result return:
  - The 32-bit reply is returned as four bytes, most significant first.
  - The first `c_stb_o` rises on the rising edge that samples `fu_done_i` high.
- R7: Latency mode:
  - Opcode 0x04 toggles latency mode. It produces no reply byte, and `busy_o` falls again.
  - While the mode is on, the reply is the start-to-done cycle count: done sampled N cycles after start gives N.
  - The count saturates at 0xFFFFFFFF.
- R8: An opcode above 0x04 is answered with the single status byte 0xEE, after which the block returns to idle with `busy_o` low.
- R9: Busy and ignored strobes:
  - `busy_o` rises with the acknowledge of the opcode byte.
  - It falls once the host acknowledge of the last reply byte is seen low.
  - A strobe raised while the arithmetic unit is working is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| h_data_i | input | 8 | Inbound byte from host |
| h_stb_i | input | 1 | Host strobe for inbound byte (asynchronous) |
| c_ack_o | output | 1 | Acknowledge for inbound byte |
| c_data_o | output | 8 | Outbound reply byte |
| c_stb_o | output | 1 | Strobe for outbound byte |
| h_ack_i | input | 1 | Host acknowledge for outbound byte (asynchronous) |
| busy_o | output | 1 | Command in progress |
| fu_start_o | output | 1 | One-cycle start to arithmetic unit |
| fu_op_o | output | 2 | Operation code: 0 add, 1 sub, 2 mul, 3 div |
| fu_a_o | output | 32 | Operand A |
| fu_b_o | output | 32 | Operand B |
| fu_done_i | input | 1 | Arithmetic unit finished |
| fu_res_i | input | 32 | Arithmetic unit result |

## Verification
Every host-side input edge reaches an output on the third rising edge after it, because it passes two synchroniser stages and then the state register. The bench therefore changes inputs just after a falling edge and samples two and three falling edges later. It expects the old value at the first sample and the new value at the second.

The start pulse is checked at the first falling edge where the acknowledge of the last operand byte reads low. It is checked again, and must be gone, one cycle later. The first reply strobe is expected low in the cycle that done is high and high in the following cycle.

A stub arithmetic unit raises done exactly N cycles after it sees start. This gives latency mode a known expected count per vector.

// File: rtl/fpu_byte_link_pkg.sv
package fpu_byte_link_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int NB     = WORD_W / BYTE_W;          // bytes per word
    localparam int OPND_W = 2 * WORD_W;               // both operands
    localparam int IDX_W  = $clog2(2 * NB + 1);       // inbound byte index
    localparam int TXI_W  = (NB > 1) ? $clog2(NB) : 1;

    localparam logic [BYTE_W-1:0] OPC_MODE = 8'h04;
    localparam logic [BYTE_W-1:0] ERR_CODE = 8'hEE;

    typedef enum logic [2:0] {
        ST_RX_WAIT,
        ST_RX_REL,
        ST_CALC,
        ST_TX_STB,
        ST_TX_REL
    } link_st_e;

    typedef struct packed {
        link_st_e            st;
        logic [IDX_W-1:0]    idx;
        logic                ack;
        logic                stb;
        logic                start;
        logic                busy;
        logic                timed;
        logic [BYTE_W-1:0]   opc;
        logic [OPND_W-1:0]   opnd;
        logic [WORD_W-1:0]   txw;
        logic [TXI_W-1:0]    txi;
    } link_regs_t;

endpackage

// File: rtl/fpu_byte_link_sync.sv
module fpu_byte_link_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= d;
                end else begin
                    chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fpu_byte_link_lat.sv
module fpu_byte_link_lat #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/fpu_byte_link.sv
module fpu_byte_link
    import fpu_byte_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] h_data_i,
    input  logic              h_stb_i,
    output logic              c_ack_o,
    output logic [BYTE_W-1:0] c_data_o,
    output logic              c_stb_o,
    input  logic              h_ack_i,
    output logic              busy_o,
    output logic              fu_start_o,
    output logic [1:0]        fu_op_o,
    output logic [WORD_W-1:0] fu_a_o,
    output logic [WORD_W-1:0] fu_b_o,
    input  logic              fu_done_i,
    input  logic [WORD_W-1:0] fu_res_i
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * NB);
    localparam logic [TXI_W-1:0] TOP_TXI  = TXI_W'(NB - 1);

    logic [1:0]        sync_in, sync_out;
    logic              stb_s, ack_s;
    logic [WORD_W-1:0] lat_cnt;
    link_regs_t        r_d, r_q;

    assign sync_in = {h_ack_i, h_stb_i};

    fpu_byte_link_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    assign stb_s = sync_out[0];
    assign ack_s = sync_out[1];

    fpu_byte_link_lat #(.CNT_W(WORD_W)) u_lat (
        .clk (clk),
        .rst (rst),
        .clr (r_q.st != ST_CALC),
        .en  (r_q.st == ST_CALC),
        .cnt (lat_cnt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        unique case (r_q.st)
            ST_RX_WAIT: begin
                if (stb_s) begin
                    r_d.ack = 1'b1;
                    r_d.st  = ST_RX_REL;
                    if (r_q.idx == '0) begin
                        r_d.opc  = h_data_i;
                        r_d.busy = 1'b1;
                    end else begin
                        r_d.opnd = {r_q.opnd[OPND_W-BYTE_W-1:0], h_data_i};
                    end
                end
            end
            ST_RX_REL: begin
                if (!stb_s) begin
                    r_d.ack = 1'b0;
                    if (r_q.idx == '0) begin
                        if (r_q.opc < OPC_MODE) begin
                            r_d.idx = IDX_W'(1);
                            r_d.st  = ST_RX_WAIT;
                        end else if (r_q.opc == OPC_MODE) begin
                            r_d.timed = !r_q.timed;
                            r_d.busy  = 1'b0;
                            r_d.st    = ST_RX_WAIT;
                        end else begin
                            r_d.txw = {{(WORD_W-BYTE_W){1'b0}}, ERR_CODE};
                            r_d.txi = '0;
                            r_d.stb = 1'b1;
                            r_d.st  = ST_TX_STB;
                        end
                    end else if (r_q.idx == LAST_IDX) begin
                        r_d.idx   = '0;
                        r_d.start = 1'b1;
                        r_d.st    = ST_CALC;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_RX_WAIT;
                    end
                end
            end
            ST_CALC: begin
                if (fu_done_i) begin
                    r_d.txw = r_q.timed ? lat_cnt : fu_res_i;
                    r_d.txi = TOP_TXI;
                    r_d.stb = 1'b1;
                    r_d.st  = ST_TX_STB;
                end
            end
            ST_TX_STB: begin
                if (ack_s) begin
                    r_d.stb = 1'b0;
                    r_d.st  = ST_TX_REL;
                end
            end
            ST_TX_REL: begin
                if (!ack_s) begin
                    if (r_q.txi == '0) begin
                        r_d.busy = 1'b0;
                        r_d.st   = ST_RX_WAIT;
                    end else begin
                        r_d.txi = r_q.txi - 1'b1;
                        r_d.stb = 1'b1;
                        r_d.st  = ST_TX_STB;
                    end
                end
            end
            default: r_d.st = ST_RX_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.st    <= ST_RX_WAIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign c_ack_o    = r_q.ack;
    assign c_stb_o    = r_q.stb;
    assign c_data_o   = r_q.txw[r_q.txi*BYTE_W +: BYTE_W];
    assign busy_o     = r_q.busy;
    assign fu_start_o = r_q.start;
    assign fu_op_o    = r_q.opc[1:0];
    assign fu_a_o     = r_q.opnd[OPND_W-1:WORD_W];
    assign fu_b_o     = r_q.opnd[WORD_W-1:0];
endmodule

// File: rtl/fpu_byte_link_chk.sv
module fpu_byte_link_chk (
    input logic       clk,
    input logic       rst,
    input logic       stb_s,
    input logic       ack_s,
    input logic       c_ack_o,
    input logic       c_stb_o,
    input logic [7:0] c_data_o,
    input logic       busy_o,
    input logic       fu_start_o
);
    AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        $rose(c_ack_o) |-> $past(stb_s));                              // R2
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (c_ack_o && stb_s) |=> c_ack_o);                               // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (c_stb_o && !ack_s) |=> (c_stb_o && $stable(c_data_o)));       // R3
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        fu_start_o |=> !fu_start_o);                                   // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        fu_start_o |-> busy_o);                                        // R9
    AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (rst)
        c_stb_o |-> !c_ack_o);                                         // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!c_ack_o && !c_stb_o && !busy_o && !fu_start_o)); // R1
endmodule

bind fpu_byte_link fpu_byte_link_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .stb_s      (stb_s),
    .ack_s      (ack_s),
    .c_ack_o    (c_ack_o),
    .c_stb_o    (c_stb_o),
    .c_data_o   (c_data_o),
    .busy_o     (busy_o),
    .fu_start_o (fu_start_o)
);

// File: tb/tb_fpu_byte_link.sv
module tb_fpu_byte_link;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  h_data = 8'h00;
    logic        h_stb = 1'b0;
    logic        h_ack = 1'b0;
    logic        c_ack, c_stb, busy, fu_start, fu_done;
    logic [7:0]  c_data;
    logic [1:0]  fu_op;
    logic [31:0] fu_a, fu_b, fu_res;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int start_hi = 0;
    logic timed_exp = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fpu_byte_link dut (
        .clk(clk), .rst(rst), .h_data_i(h_data), .h_stb_i(h_stb), .c_ack_o(c_ack),
        .c_data_o(c_data), .c_stb_o(c_stb), .h_ack_i(h_ack), .busy_o(busy),
        .fu_start_o(fu_start), .fu_op_o(fu_op), .fu_a_o(fu_a), .fu_b_o(fu_b),
        .fu_done_i(fu_done), .fu_res_i(fu_res)
    );

    // stub arithmetic unit: done exactly stub_lat cycles after start
    logic [7:0]  stub_lat = 8'd1;
    logic [7:0]  rem;
    logic        done_r;
    logic [1:0]  cap_op;
    logic [31:0] cap_a, cap_b;

    always @(posedge clk) begin
        if (rst) begin
            rem <= 8'd0; done_r <= 1'b0; cap_op <= 2'd0; cap_a <= 32'd0; cap_b <= 32'd0;
        end else if (fu_start) begin
            cap_op <= fu_op; cap_a <= fu_a; cap_b <= fu_b;
            if (stub_lat <= 8'd1) begin done_r <= 1'b1; rem <= 8'd0; end
            else begin rem <= stub_lat - 8'd1; done_r <= 1'b0; end
        end else if (rem != 8'd0) begin
            rem <= rem - 8'd1; done_r <= (rem == 8'd1);
        end else begin
            done_r <= 1'b0;
        end
    end
    assign fu_done = done_r;
    assign fu_res  = (cap_a ^ {cap_b[15:0], cap_b[31:16]}) + {30'd0, cap_op};

    function automatic logic [31:0] model(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
        return (a ^ {b[15:0], b[31:16]}) + {30'd0, op[1:0]};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (fu_start) start_hi++;
        if (cyc == 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_ack(input logic lvl);
        int n = 0;
        while (c_ack !== lvl && n < 300) begin @(negedge clk); n++; end
        if (n >= 300) chk("R2 ack timeout", {31'd0, c_ack}, {31'd0, lvl});
    endtask

    task automatic wait_cstb(input logic lvl);
        int n = 0;
        while (c_stb !== lvl && n < 300) begin @(negedge clk); n++; end
        if (n >= 300) chk("R3 strobe timeout", {31'd0, c_stb}, {31'd0, lvl});
    endtask

    task automatic send_byte(input logic [7:0] b);
        h_data = b; h_stb = 1'b1;
        wait_ack(1'b1);
        h_stb = 1'b0;
        wait_ack(1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        wait_cstb(1'b1);
        v = c_data;
        h_ack = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 strobe held until ack seen", {31'd0, c_stb}, 32'd1);
        chk("R3 data stable", {24'd0, c_data}, {24'd0, v});
        @(negedge clk);
        chk("R3 strobe drops 3 edges after ack", {31'd0, c_stb}, 32'd0);
        h_ack = 1'b0;
    endtask

    task automatic send_operands(input logic [31:0] a, input logic [31:0] b);
        for (int i = 3; i >= 0; i--) send_byte(a[i*8 +: 8]);
        for (int i = 3; i >= 0; i--) send_byte(b[i*8 +: 8]);
        chk("R5 start with last ack fall", {31'd0, fu_start}, 32'd1);
        @(negedge clk);
        chk("R5 start lasts one cycle", {31'd0, fu_start}, 32'd0);
    endtask

    task automatic get_reply(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [7:0] lat);
        logic [31:0] w;
        logic [7:0]  v;
        int n = 0;
        while (!fu_done && n < 400) begin @(negedge clk); n++; end
        chk("R6 strobe low in done cycle", {31'd0, c_stb}, 32'd0);
        @(negedge clk);
        chk("R6 strobe one cycle after done", {31'd0, c_stb}, 32'd1);
        for (int i = 3; i >= 0; i--) begin recv_byte(v); w[i*8 +: 8] = v; end
        if (timed_exp) chk("R7 latency count", w, {24'd0, lat});
        else           chk("R6 result word MSB first", w, model(op, a, b));
        chk("R4 op code", {30'd0, cap_op}, {30'd0, op[1:0]});
        chk("R4 operand A", cap_a, a);
        chk("R4 operand B", cap_b, b);
        chk("R5 one start per frame", start_hi, 1);
        repeat (4) @(negedge clk);
        chk("R9 busy low after last byte", {31'd0, busy}, 32'd0);
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [7:0] lat);
        logic [7:0] v;
        stub_lat = lat; start_hi = 0;
        send_byte(op);
        if (op == 8'h04) begin
            timed_exp = !timed_exp;
            repeat (8) @(negedge clk);
            chk("R7 mode opcode sends nothing", {31'd0, c_stb}, 32'd0);
            chk("R7 mode opcode leaves busy low", {31'd0, busy}, 32'd0);
        end else if (op > 8'h04) begin
            recv_byte(v);
            chk("R8 error status byte", {24'd0, v}, 32'h0000_00EE);
            repeat (4) @(negedge clk);
            chk("R8 idle after error", {31'd0, busy}, 32'd0);
        end else begin
            chk("R9 busy after opcode", {31'd0, busy}, 32'd1);
            send_operands(a, b);
            get_reply(op, a, b, lat);
        end
    endtask

    // {opcode, operand A, operand B, stub latency}
    localparam int NV = 9;
    localparam logic [79:0] VEC [NV] = '{
        {8'h00, 32'h3F80_0000, 32'h4000_0000, 8'd3},
        {8'h01, 32'hC120_0000, 32'h3E80_0000, 8'd1},
        {8'h04, 32'h0000_0000, 32'h0000_0000, 8'd0},
        {8'h02, 32'h4049_0FDB, 32'h402D_F854, 8'd17},
        {8'h03, 32'h7F80_0000, 32'h0000_0001, 8'd5},
        {8'h04, 32'h0000_0000, 32'h0000_0000, 8'd0},
        {8'h07, 32'h0000_0000, 32'h0000_0000, 8'd0},
        {8'h03, 32'h8000_0000, 32'h7FC0_0000, 8'd2},
        {8'hFF, 32'h0000_0000, 32'h0000_0000, 8'd0}
    };

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ack", {31'd0, c_ack}, 32'd0);
        chk("R1 reset strobe", {31'd0, c_stb}, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset start", {31'd0, fu_start}, 32'd0);

        for (int k = 0; k < NV; k++)
            run_cmd(VEC[k][79:72], VEC[k][71:40], VEC[k][39:8], VEC[k][7:0]);

        // R2: inbound acknowledge latency, probed on an opcode byte
        stub_lat = 8'd4; start_hi = 0;
        h_data = 8'h01; h_stb = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 ack not before third edge", {31'd0, c_ack}, 32'd0);
        @(negedge clk);
        chk("R2 ack at third edge", {31'd0, c_ack}, 32'd1);
        chk("R9 busy with opcode ack", {31'd0, busy}, 32'd1);
        h_stb = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 ack held two edges after strobe drop", {31'd0, c_ack}, 32'd1);
        @(negedge clk);
        chk("R2 ack falls at third edge", {31'd0, c_ack}, 32'd0);
        send_operands(32'h1234_5678, 32'h9ABC_DEF0);
        get_reply(8'h01, 32'h1234_5678, 32'h9ABC_DEF0, 8'd4);

        // R9: strobe during computation is not acknowledged
        stub_lat = 8'd40; start_hi = 0;
        send_byte(8'h02);
        send_operands(32'h4110_0000, 32'hBF00_0000);
        repeat (3) @(negedge clk);
        h_data = 8'h55; h_stb = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 no ack while computing", {31'd0, c_ack}, 32'd0);
        chk("R9 busy while computing", {31'd0, busy}, 32'd1);
        h_stb = 1'b0;
        repeat (3) @(negedge clk);
        get_reply(8'h02, 32'h4110_0000, 32'hBF00_0000, 8'd40);

        // R1: reset clears latency mode
        send_byte(8'h04);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        timed_exp = 1'b0;
        @(negedge clk);
        stub_lat = 8'd6; start_hi = 0;
        send_byte(8'h00);
        send_operands(32'h0000_0001, 32'h0000_0002);
        get_reply(8'h00, 32'h0000_0001, 32'h0000_0002, 8'd6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule